// File: doc/BRIEF.md
# PCI Command and Status Register Block

This block holds the command and status words of the PCI configuration header for a network controller that can act as both a bus master and a target. The command word carries the enables for I/O decode, memory decode, bus mastering, parity response and system-error signalling. The block uses the two decode enables to qualify the raw address-decode hits coming from the bus interface. The result is the claim outputs for the I/O window, the memory-mapped register window and the expansion ROM.

The status word records four error conditions in sticky bits: data or address parity errors, signalled system errors, received master aborts and received target aborts. The bus interface presents the current bus mode, phase, command code, handshake lines and parity-check result each cycle, and the block decides from these whether an error bit is set. Software clears a status bit by writing 1 to it. Only the hard reset clears the registers. The soft reset and the stop control leave both words untouched.

Top module: `pci_cmdsts`

## Requirements
- R1: While `hrst_n` is low, the command word and the status word are 0, so `cfg_rdata` reads 32'h0.
- R2: `cfg_rdata[15:0]` shows the command word and `cfg_rdata[31:16]` shows the status word. A write (`cfg_wr` and `cfg_sel`) updates command bits 7:0 when `cfg_be[0]` is set and bits 15:8 when `cfg_be[1]` is set. Only command bits 0 (I/O enable), 1 (memory enable), 2 (bus master enable), 6 (parity response enable) and 8 (system error enable) can be written; all other command bits read 0. Status bits 11:0 read 0.
- R3: `io_claim` is asserted only while `io_hit` is 1 and command bit 0 is 1.
- R4: `mem_claim` equals `mem_hit` gated by command bit 1. `rom_claim` is asserted only while `rom_hit`, `rom_en` and command bit 1 are all 1.
- R5: `srst` and `stop_bit` change neither the command word nor any status bit.
- R6: Status bit 15 is set when `par_err` is seen in either of two slave-mode cases (`bus_master`=0). The first is any address phase (`addr_phase`). The second is a data phase (`data_phase`) with `dev_sel`, `irdy` and `trdy` all 1, for the write command codes 4'b0011, 4'b0111, 4'b1011 or 4'b1111.
- R7: In master mode, status bit 15 is set in two cases, both during a data phase. The first is `par_err` on a memory read (command codes 4'b0110, 4'b1100, 4'b1110). The second is `perr_in` on a memory write (4'b0111, 4'b1111). Command bit 6 has no influence on bit 15.
- R8: Status bit 14 is set on a slave-mode address-phase parity error only when command bits 8 and 6 are both 1.
- R9: Status bit 13 is set by `mst_abort` and status bit 12 by `tgt_abort`.
- R10: A write with `cfg_be[3]` set clears each of status bits 15:12 whose `cfg_wdata` bit (31:28) is 1. Zeros, or a write without `cfg_be[3]`, leave them unchanged. Without such a write a set status bit stays set.
- R11: When a status bit's set condition and a write-1 clear of that bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| srst | input | 1 | Soft reset (no effect on these registers) |
| stop_bit | input | 1 | Stop control (no effect on these registers) |
| cfg_sel | input | 1 | Configuration access targets this dword |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Status word in the upper half, command word in the lower half |
| bus_master | input | 1 | 1 = master mode, 0 = slave mode |
| addr_phase | input | 1 | Current cycle is an address phase |
| data_phase | input | 1 | Current cycle is a data phase |
| bus_cmd | input | 4 | PCI command code of the transaction |
| dev_sel | input | 1 | Transaction selects this device |
| irdy | input | 1 | Initiator ready sampled |
| trdy | input | 1 | Target ready sampled |
| par_err | input | 1 | Parity checker reports an error this cycle |
| perr_in | input | 1 | Target drives PERR during a master write |
| mst_abort | input | 1 | Own master cycle ended with master abort |
| tgt_abort | input | 1 | Own master cycle ended with target abort |
| io_hit | input | 1 | Raw I/O window decode hit |
| mem_hit | input | 1 | Raw memory-mapped register window hit |
| rom_hit | input | 1 | Raw expansion ROM decode hit |
| rom_en | input | 1 | ROM enable bit of the ROM base register |
| io_claim | output | 1 | Qualified I/O claim |
| mem_claim | output | 1 | Qualified memory window claim |
| rom_claim | output | 1 | Qualified expansion ROM claim |

## Verification
The hardest situation to reach is a status bit whose set condition lands in the same cycle as a write-1 clear of that bit. The bus inputs and the configuration write must then be aligned to one edge. The bench builds this on purpose by driving a slave address-phase parity error together with a clearing write. A long randomized phase then mixes modes, phases, command codes and byte-enabled writes. This reaches the narrow master-write PERR case and the two-bit system-error gate many times. A behavioural model checks every cycle.

// File: rtl/pci_cmdsts.sv
module pci_cmdsts #(
  parameter logic [15:0] CMD_WMASK = 16'h0147,
  parameter logic [15:0] STS_W1C   = 16'hF000
) (
  input  logic        clk,
  input  logic        hrst_n,
  input  logic        srst,
  input  logic        stop_bit,
  input  logic        cfg_sel,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        bus_master,
  input  logic        addr_phase,
  input  logic        data_phase,
  input  logic [3:0]  bus_cmd,
  input  logic        dev_sel,
  input  logic        irdy,
  input  logic        trdy,
  input  logic        par_err,
  input  logic        perr_in,
  input  logic        mst_abort,
  input  logic        tgt_abort,
  input  logic        io_hit,
  input  logic        mem_hit,
  input  logic        rom_hit,
  input  logic        rom_en,
  output logic        io_claim,
  output logic        mem_claim,
  output logic        rom_claim
);

  localparam logic [3:0] C_IO_WR   = 4'b0011;
  localparam logic [3:0] C_MEM_RD  = 4'b0110;
  localparam logic [3:0] C_MEM_WR  = 4'b0111;
  localparam logic [3:0] C_CFG_WR  = 4'b1011;
  localparam logic [3:0] C_MEM_RDM = 4'b1100;
  localparam logic [3:0] C_MEM_RDL = 4'b1110;
  localparam logic [3:0] C_MEM_WRI = 4'b1111;

  logic [15:0] cmd_q, sts_q;
  logic [15:0] cmd_bmask, sts_bmask, sts_clr, sts_set;
  logic        cmd_wr, is_mrd, is_mwr, is_swr;
  logic        addr_pe, slv_data_pe, mst_rd_pe, mst_wr_pe, pe_set, serr_set;

  assign cmd_wr    = cfg_wr & cfg_sel;
  assign cmd_bmask = {{8{cmd_wr & cfg_be[1]}}, {8{cmd_wr & cfg_be[0]}}};
  assign sts_bmask = {{8{cmd_wr & cfg_be[3]}}, {8{cmd_wr & cfg_be[2]}}};
  assign sts_clr   = cfg_wdata[31:16] & sts_bmask;

  assign is_mrd = (bus_cmd == C_MEM_RD) | (bus_cmd == C_MEM_RDM) | (bus_cmd == C_MEM_RDL);
  assign is_mwr = (bus_cmd == C_MEM_WR) | (bus_cmd == C_MEM_WRI);
  assign is_swr = is_mwr | (bus_cmd == C_IO_WR) | (bus_cmd == C_CFG_WR);

  assign addr_pe     = ~bus_master & addr_phase & par_err;
  assign slv_data_pe = ~bus_master & data_phase & dev_sel & irdy & trdy & is_swr & par_err;
  assign mst_rd_pe   =  bus_master & data_phase & is_mrd & par_err;
  assign mst_wr_pe   =  bus_master & data_phase & is_mwr & perr_in;
  assign pe_set      = addr_pe | slv_data_pe | mst_rd_pe | mst_wr_pe;
  assign serr_set    = addr_pe & cmd_q[8] & cmd_q[6];
  assign sts_set     = {pe_set, serr_set, mst_abort, tgt_abort, 12'h000};

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      cmd_q <= '0;
      sts_q <= '0;
    end else begin
      cmd_q <= ((cmd_q & ~cmd_bmask) | (cfg_wdata[15:0] & cmd_bmask)) & CMD_WMASK;
      sts_q <= ((sts_q & ~sts_clr) | sts_set) & STS_W1C;
    end
  end

  assign cfg_rdata = {sts_q, cmd_q};
  assign io_claim  = io_hit  & cmd_q[0];
  assign mem_claim = mem_hit & cmd_q[1];
  assign rom_claim = rom_hit & rom_en & cmd_q[1];

  AST_IO_OFF_NO_CLAIM: assert property (@(posedge clk) disable iff (!hrst_n)
    $fell(cmd_q[0]) |-> !io_claim); // R3

  AST_MEM_OFF_NO_CLAIM: assert property (@(posedge clk) disable iff (!hrst_n)
    $fell(cmd_q[1]) |-> (!mem_claim && !rom_claim)); // R4

  AST_SOFT_KEEPS_CMD: assert property (@(posedge clk) disable iff (!hrst_n)
    ((srst || stop_bit) && !(cmd_wr && (cfg_be[1] || cfg_be[0]))) |=> $stable(cmd_q)); // R5

  AST_SERR_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!hrst_n)
    $rose(sts_q[14]) |-> $past(cmd_q[8] && cmd_q[6] && addr_phase && par_err && !bus_master)); // R8

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!hrst_n)
    !(cmd_wr && cfg_be[3]) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R10

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!hrst_n)
    pe_set |=> sts_q[15]); // R11

endmodule

// File: tb/pci_cmdsts_bench.sv
module pci_cmdsts_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        hrst_n = 1'b0, srst = 1'b0, stop_bit = 1'b0;
  logic        cfg_sel = 1'b0, cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_master = 1'b0, addr_phase = 1'b0, data_phase = 1'b0;
  logic [3:0]  bus_cmd = '0;
  logic        dev_sel = 1'b0, irdy = 1'b0, trdy = 1'b0, par_err = 1'b0, perr_in = 1'b0;
  logic        mst_abort = 1'b0, tgt_abort = 1'b0;
  logic        io_hit = 1'b0, mem_hit = 1'b0, rom_hit = 1'b0, rom_en = 1'b0;
  logic        io_claim, mem_claim, rom_claim;

  pci_cmdsts u_pci_cmdsts (
    .clk(clk), .hrst_n(hrst_n), .srst(srst), .stop_bit(stop_bit),
    .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_master(bus_master), .addr_phase(addr_phase),
    .data_phase(data_phase), .bus_cmd(bus_cmd), .dev_sel(dev_sel), .irdy(irdy),
    .trdy(trdy), .par_err(par_err), .perr_in(perr_in), .mst_abort(mst_abort),
    .tgt_abort(tgt_abort), .io_hit(io_hit), .mem_hit(mem_hit), .rom_hit(rom_hit),
    .rom_en(rom_en), .io_claim(io_claim), .mem_claim(mem_claim), .rom_claim(rom_claim)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_cmd = '0, m_sts = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    logic [15:0] set_v, clr_v;
    bit mrd, mwr, swr, ape;
    if (!hrst_n) begin
      m_cmd = '0;
      m_sts = '0;
    end else begin
      mrd = (bus_cmd inside {4'b0110, 4'b1100, 4'b1110});
      mwr = (bus_cmd inside {4'b0111, 4'b1111});
      swr = mwr || (bus_cmd inside {4'b0011, 4'b1011});
      ape = !bus_master && addr_phase && par_err;
      set_v = '0;
      if (ape) set_v[15] = 1'b1;
      if (!bus_master && data_phase && dev_sel && irdy && trdy && swr && par_err) set_v[15] = 1'b1;
      if (bus_master && data_phase && mrd && par_err) set_v[15] = 1'b1;
      if (bus_master && data_phase && mwr && perr_in) set_v[15] = 1'b1;
      if (ape && m_cmd[8] && m_cmd[6]) set_v[14] = 1'b1;
      if (mst_abort) set_v[13] = 1'b1;
      if (tgt_abort) set_v[12] = 1'b1;
      clr_v = (cfg_wr && cfg_sel && cfg_be[3]) ? {cfg_wdata[31:28], 12'h000} : 16'h0;
      if (cfg_wr && cfg_sel && cfg_be[0]) m_cmd[7:0]  = cfg_wdata[7:0] & 8'h47;
      if (cfg_wr && cfg_sel && cfg_be[1]) m_cmd[15:8] = cfg_wdata[15:8] & 8'h01;
      m_sts = (m_sts & ~clr_v) | set_v;
    end
  end

  task automatic compare_all();
    chk("R2 command half", {16'h0, cfg_rdata[15:0]}, {16'h0, m_cmd});
    chk("R2 unused status bits", {20'h0, cfg_rdata[27:16]}, 32'h0);
    chk("R6 or R7 status bit15", {31'h0, cfg_rdata[31]}, {31'h0, m_sts[15]});
    chk("R8 status bit14", {31'h0, cfg_rdata[30]}, {31'h0, m_sts[14]});
    chk("R9 status bits13:12", {30'h0, cfg_rdata[29:28]}, {30'h0, m_sts[13:12]});
    chk("R3 io_claim", {31'h0, io_claim}, {31'h0, io_hit & m_cmd[0]});
    chk("R4 mem_claim", {31'h0, mem_claim}, {31'h0, mem_hit & m_cmd[1]});
    chk("R4 rom_claim", {31'h0, rom_claim}, {31'h0, rom_hit & rom_en & m_cmd[1]});
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    cfg_wr = 0; cfg_sel = 0; cfg_be = '0; cfg_wdata = '0;
    bus_master = 0; addr_phase = 0; data_phase = 0; bus_cmd = '0;
    dev_sel = 0; irdy = 0; trdy = 0; par_err = 0; perr_in = 0;
    mst_abort = 0; tgt_abort = 0; srst = 0; stop_bit = 0;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    cfg_wr = 1; cfg_sel = 1; cfg_be = be; cfg_wdata = d;
    step();
    cfg_wr = 0; cfg_sel = 0; cfg_be = '0; cfg_wdata = '0;
  endtask

  task automatic clear_all();
    wr(4'b1000, 32'hF000_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    hrst_n = 0;
    cfg_wr = 1; cfg_sel = 1; cfg_be = 4'hF; cfg_wdata = 32'hFFFF_FFFF;
    mst_abort = 1; io_hit = 1; mem_hit = 1;
    step(); step();
    chk("R1 reset read", cfg_rdata, 32'h0);
    chk("R1 reset io_claim", {31'h0, io_claim}, 32'h0);
    idle(); io_hit = 0; mem_hit = 0;
    @(negedge clk); hrst_n = 1;
    step();

    // R2: byte enables and writable mask
    wr(4'b0001, 32'hFFFF_FFFF);
    chk("R2 low byte only", cfg_rdata, 32'h0000_0047);
    wr(4'b0010, 32'h0000_FFFF);
    chk("R2 high byte", cfg_rdata, 32'h0000_0147);
    wr(4'b0011, 32'h0000_0000);
    chk("R2 cleared", cfg_rdata, 32'h0);

    // R3 / R4 gating
    io_hit = 1; mem_hit = 1; rom_hit = 1; rom_en = 1;
    step();
    chk("R3 io off", {31'h0, io_claim}, 32'h0);
    chk("R4 rom off", {31'h0, rom_claim}, 32'h0);
    wr(4'b0001, 32'h0000_0003);
    chk("R3 io on", {31'h0, io_claim}, 32'h1);
    chk("R4 rom on", {31'h0, rom_claim}, 32'h1);
    rom_en = 0; step();
    chk("R4 rom needs rom_en", {31'h0, rom_claim}, 32'h0);
    chk("R4 mem on", {31'h0, mem_claim}, 32'h1);
    io_hit = 0; mem_hit = 0; rom_hit = 0;

    // R9 then R5
    mst_abort = 1; step(); mst_abort = 0;
    tgt_abort = 1; step(); tgt_abort = 0;
    chk("R9 aborts logged", cfg_rdata, 32'h3000_0003);
    srst = 1; stop_bit = 1; step(); step(); srst = 0; stop_bit = 0;
    chk("R5 soft reset keeps", cfg_rdata, 32'h3000_0003);

    // R10
    wr(4'b1000, 32'h0000_0000);
    chk("R10 write zero", cfg_rdata, 32'h3000_0003);
    wr(4'b0111, 32'hF000_0003);
    chk("R10 no be3", cfg_rdata, 32'h3000_0003);
    wr(4'b1000, 32'h2000_0000);
    chk("R10 clear bit13", cfg_rdata, 32'h1000_0003);
    clear_all();

    // R6 slave cases
    addr_phase = 1; par_err = 1; step(); idle();
    chk("R6 slave addr pe", cfg_rdata, 32'h8000_0003);
    clear_all();
    data_phase = 1; dev_sel = 1; irdy = 1; trdy = 0; bus_cmd = 4'b1011; par_err = 1;
    step();
    chk("R6 no transfer", cfg_rdata[31:16], 32'h0);
    trdy = 1; bus_cmd = 4'b0110; step();
    chk("R6 read ignored", cfg_rdata[31:16], 32'h0);
    bus_cmd = 4'b1011; step(); idle();
    chk("R6 cfg write pe", cfg_rdata[31:16], 32'h8000);
    clear_all();

    // R7 master cases, bit6 clear
    bus_master = 1; data_phase = 1; bus_cmd = 4'b0111; par_err = 1; step();
    chk("R7 mwr par_err ignored", cfg_rdata[31:16], 32'h0);
    par_err = 0; perr_in = 1; step(); idle();
    chk("R7 mwr perr", cfg_rdata[31:16], 32'h8000);
    clear_all();
    bus_master = 1; data_phase = 1; bus_cmd = 4'b1110; par_err = 1; step(); idle();
    chk("R7 mrd pe", cfg_rdata[31:16], 32'h8000);
    clear_all();

    // R8 gating
    addr_phase = 1; par_err = 1; step(); idle();
    chk("R8 serr off", cfg_rdata[31:16], 32'h8000);
    clear_all();
    wr(4'b0011, 32'h0000_0040);
    addr_phase = 1; par_err = 1; step(); idle();
    chk("R8 only bit6", cfg_rdata[31:16], 32'h8000);
    clear_all();
    wr(4'b0011, 32'h0000_0140);
    addr_phase = 1; par_err = 1; step(); idle();
    chk("R8 both enables", cfg_rdata[31:16], 32'hC000);

    // R11 set wins against clear
    addr_phase = 1; par_err = 1;
    cfg_wr = 1; cfg_sel = 1; cfg_be = 4'b1000; cfg_wdata = 32'hF000_0000;
    step(); idle();
    chk("R11 set beats clear", cfg_rdata[31:16], 32'hC000);
    clear_all();

    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      bus_master = 1'($urandom % 2);
      addr_phase = 1'($urandom % 2);
      data_phase = 1'($urandom % 2);
      bus_cmd    = 4'($urandom);
      dev_sel    = 1'($urandom % 2);
      irdy       = 1'($urandom % 2);
      trdy       = 1'($urandom % 2);
      par_err    = ($urandom % 4) == 0;
      perr_in    = ($urandom % 4) == 0;
      mst_abort  = ($urandom % 10) == 0;
      tgt_abort  = ($urandom % 10) == 0;
      io_hit     = 1'($urandom % 2);
      mem_hit    = 1'($urandom % 2);
      rom_hit    = 1'($urandom % 2);
      rom_en     = 1'($urandom % 2);
      srst       = ($urandom % 8) == 0;
      stop_bit   = ($urandom % 8) == 0;
      cfg_wr     = ($urandom % 5) == 0;
      cfg_sel    = ($urandom % 4) != 0;
      cfg_be     = 4'($urandom);
      cfg_wdata  = $urandom;
      hrst_n     = ($urandom % 700) != 0;
      step();
    end
    idle(); hrst_n = 1;
    step();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule